// File: doc/BRIEF.md
# Successive-Approximation Converter Readout Controller

This block sits on the host side of a three-wire serial link to an external 12-bit successive-approximation converter. It runs one conversion for each start request. It drives an active-low select line low, and the converter also treats that line as its power-down control. It then generates a serial clock from the system clock. The serial clock's half period is programmed in system clocks. The controller lets the converter's acquisition window and null bit go by, and shifts in twelve result bits, most significant first. It then raises select again and presents the result together with a one-cycle strobe.

A frame always spans sixteen serial clock periods, so the divider setting fixes the sample rate at one sixteenth of the serial clock. A divider setting that would drive the link faster than the converter tolerates is refused, and so is one slow enough that the hold capacitor droops. A refused setting starts no frame. The serial clock rests at a selectable idle level between frames, which gives idle-low or idle-high operation. Requests that arrive while a frame or the enforced select-high gap is in progress are remembered and served once the gap has elapsed.

Top module: `sar_rd_ctrl`

## Requirements
- R1: After reset `cs_n_o` is 1, `busy` and `done` are 0, `result` is 0, and `sclk_o` equals `cpol`.
- R2: A `start` seen in idle with `half_div` in [MIN_HALF, MAX_HALF] drives `cs_n_o` low on the next clock. `cs_n_o` then stays low for exactly 32 x `half_div` clocks.
- R3: While `cs_n_o` is high, `sclk_o` equals `cpol` (0 = idle low, 1 = idle high). Within a frame, each serial period is `half_div` clocks low followed by `half_div` clocks high, so every frame carries exactly 16 rising edges. Both polarities yield the same result.
- R4: Rising edges are numbered 1 to 16 within a frame. `sdata_in` is captured on the clock where `sclk_o` rises. Edges 4 through 15 carry result bits 11 down to 0, and the value on edges 1, 2, 3 and 16 has no effect on `result`. The result is straight binary.
- R5: `done` is a one-clock pulse in the first clock with `cs_n_o` high after a frame, and the new `result` is valid in that same clock. `result` then holds until the next `done`.
- R6: `busy` is 1 exactly in the clocks where `cs_n_o` is 0.
- R7: A `start` that arrives during a frame, in the `done` clock, or during the select-high gap is held. The next frame then begins after `cs_n_o` has been high for exactly max(`gap_min`,1)+1 clocks. `cs_n_o` is never low again sooner than `gap_min` clocks after it rose.
- R8: With `half_div` below MIN_HALF (default 79) or above MAX_HALF (default 12500), a `start` is dropped. `cs_n_o` stays high and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one conversion |
| cpol | input | 1 | Serial clock idle level |
| half_div | input | DIV_W | Serial clock half period in system clocks |
| gap_min | input | GAP_W | Minimum select-high clocks between frames |
| sdata_in | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| cs_n_o | output | 1 | Active-low select / power-down |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle result strobe |
| result | output | 12 | Last converted word |

## Verification
The end of a frame and a fresh start request can land in the same clock. In that clock `done` pulses while `start` is high, and the request must be held rather than lost or served early. The bench raises `start` in the exact clock where it sees `done`, and also in the middle of a frame. It then measures the select-high run before the next frame against max(`gap_min`,1)+1 and checks that the second word reads back correctly.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

    localparam int FRAME_PER  = 16;
    localparam int RES_BITS   = 12;
    localparam int PER_W      = $clog2(FRAME_PER);
    // zero-based serial periods whose rising edge carries a result bit
    localparam logic [PER_W-1:0] DATA_FIRST_PER = PER_W'(3);
    localparam logic [PER_W-1:0] DATA_LAST_PER  = PER_W'(3 + RES_BITS - 1);
    localparam logic [PER_W-1:0] FINAL_PER      = PER_W'(FRAME_PER - 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FRAME,
        ST_GAP
    } rd_state_e;

    typedef struct packed {
        logic [PER_W-1:0] per;
        logic             hi;
    } sclk_pos_t;

    function automatic logic div_in_range(input int unsigned d,
                                          input int unsigned lo,
                                          input int unsigned hi);
        return (d >= lo) && (d <= hi);
    endfunction

endpackage

// File: rtl/sar_sclk_gen.sv
module sar_sclk_gen
    import sar_rd_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_len,
    output sclk_pos_t        pos,
    output logic             rise_tick,
    output logic             end_tick
);
    logic [DIV_W-1:0] cnt;
    logic             tick;

    assign tick      = run && (cnt == half_len - DIV_W'(1));
    assign rise_tick = tick && !pos.hi;
    assign end_tick  = tick && pos.hi && (pos.per == FINAL_PER);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            pos <= '0;
        end else if (tick) begin
            cnt    <= '0;
            pos.hi <= !pos.hi;
            if (pos.hi) begin
                pos.per <= pos.per + PER_W'(1);
            end
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/sar_shift_in.sv
module sar_shift_in
    import sar_rd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                shift_en,
    input  logic                din,
    output logic [RES_BITS-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            word <= '0;
        end else if (shift_en) begin
            word <= {word[RES_BITS-2:0], din};
        end
    end
endmodule

// File: rtl/sar_gap_timer.sv
module sar_gap_timer #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [GAP_W-1:0] gap_min,
    output logic             expired
);
    logic [GAP_W-1:0] cnt;

    assign expired = (cnt >= gap_min);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (arm) begin
            cnt <= GAP_W'(1);
        end else if (!expired) begin
            cnt <= cnt + GAP_W'(1);
        end
    end
endmodule

// File: rtl/sar_rd_ctrl.sv
module sar_rd_ctrl
    import sar_rd_pkg::*;
#(
    parameter int DIV_W    = 16,
    parameter int GAP_W    = 8,
    parameter int MIN_HALF = 79,
    parameter int MAX_HALF = 12500
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                cpol,
    input  logic [DIV_W-1:0]    half_div,
    input  logic [GAP_W-1:0]    gap_min,
    input  logic                sdata_in,
    output logic                sclk_o,
    output logic                cs_n_o,
    output logic                busy,
    output logic                done,
    output logic [RES_BITS-1:0] result
);
    rd_state_e           st;
    logic                pend;
    logic [DIV_W-1:0]    half_q;
    logic                div_ok;
    logic                req;
    logic                launch;
    sclk_pos_t           pos;
    logic                rise_tick;
    logic                end_tick;
    logic                cap_en;
    logic                gap_done;
    logic [RES_BITS-1:0] shift_word;

    assign div_ok = div_in_range(int'(half_div), MIN_HALF, MAX_HALF);
    assign req    = start || pend;
    assign launch = (st == ST_IDLE) && req && div_ok;
    assign cap_en = rise_tick && (pos.per >= DATA_FIRST_PER) && (pos.per <= DATA_LAST_PER);
    assign sclk_o = cs_n_o ? cpol : pos.hi;

    sar_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
        .clk       (clk),
        .rst       (rst),
        .run       (st == ST_FRAME),
        .half_len  (half_q),
        .pos       (pos),
        .rise_tick (rise_tick),
        .end_tick  (end_tick)
    );

    sar_shift_in u_shift (
        .clk      (clk),
        .rst      (rst),
        .clr      (launch),
        .shift_en (cap_en),
        .din      (sdata_in),
        .word     (shift_word)
    );

    sar_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .arm     ((st == ST_FRAME) && end_tick),
        .gap_min (gap_min),
        .expired (gap_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            pend   <= 1'b0;
            half_q <= DIV_W'(MIN_HALF);
            cs_n_o <= 1'b1;
            busy   <= 1'b0;
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (req) begin
                        pend <= 1'b0;
                    end
                    if (launch) begin
                        st     <= ST_FRAME;
                        half_q <= half_div;
                        cs_n_o <= 1'b0;
                        busy   <= 1'b1;
                    end
                end
                ST_FRAME: begin
                    if (start) begin
                        pend <= 1'b1;
                    end
                    if (end_tick) begin
                        st     <= ST_GAP;
                        cs_n_o <= 1'b1;
                        busy   <= 1'b0;
                        done   <= 1'b1;
                        result <= shift_word;
                    end
                end
                ST_GAP: begin
                    if (start) begin
                        pend <= 1'b1;
                    end
                    if (gap_done) begin
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sar_rd_ctrl_chk.sv
module sar_rd_ctrl_chk
    import sar_rd_pkg::*;
#(
    parameter int DIV_W    = 16,
    parameter int GAP_W    = 8,
    parameter int MIN_HALF = 79,
    parameter int MAX_HALF = 12500
) (
    input logic                clk,
    input logic                rst,
    input logic                cpol,
    input logic [DIV_W-1:0]    half_div,
    input logic [GAP_W-1:0]    gap_min,
    input logic                sclk_o,
    input logic                cs_n_o,
    input logic                busy,
    input logic                done,
    input logic [RES_BITS-1:0] result
);
    logic [GAP_W:0] hi_cnt;
    logic           seen_frame;
    logic           cfg_ok;

    assign cfg_ok = div_in_range(int'(half_div), MIN_HALF, MAX_HALF);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt     <= '0;
            seen_frame <= 1'b0;
        end else if (cs_n_o) begin
            if (hi_cnt != '1) begin
                hi_cnt <= hi_cnt + (GAP_W+1)'(1);
            end
        end else begin
            hi_cnt     <= '0;
            seen_frame <= 1'b1;
        end
    end

    // R6
    busy_vs_select_chk: assert property (@(posedge clk) disable iff (rst)
        busy == !cs_n_o);

    // R3
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> (sclk_o == cpol));

    // R5
    done_at_release_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_n_o && !$past(cs_n_o)));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    // R7
    gap_min_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_frame && $fell(cs_n_o)) |-> (hi_cnt >= {1'b0, gap_min}));

    // R8
    bad_div_no_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !cfg_ok) |=> !busy);
endmodule

bind sar_rd_ctrl sar_rd_ctrl_chk #(
    .DIV_W    (DIV_W),
    .GAP_W    (GAP_W),
    .MIN_HALF (MIN_HALF),
    .MAX_HALF (MAX_HALF)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cpol     (cpol),
    .half_div (half_div),
    .gap_min  (gap_min),
    .sclk_o   (sclk_o),
    .cs_n_o   (cs_n_o),
    .busy     (busy),
    .done     (done),
    .result   (result)
);

// File: tb/sar_rd_ctrl_tb.sv
module sar_rd_ctrl_tb;
    localparam int DIV_W = 16;
    localparam int GAP_W = 8;
    localparam int MIN_H = 79;
    localparam int MAX_H = 12500;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             cpol = 1'b0;
    logic [DIV_W-1:0] half_div = DIV_W'(MIN_H);
    logic [GAP_W-1:0] gap_min = '0;
    logic             sdata = 1'b0;
    logic             sclk;
    logic             csn;
    logic             busy;
    logic             done;
    logic [11:0]      result;

    always #2 clk = ~clk;

    sar_rd_ctrl #(.DIV_W(DIV_W), .GAP_W(GAP_W), .MIN_HALF(MIN_H), .MAX_HALF(MAX_H)) u_dut (
        .clk(clk), .rst(rst), .start(start), .cpol(cpol), .half_div(half_div),
        .gap_min(gap_min), .sdata_in(sdata), .sclk_o(sclk), .cs_n_o(csn),
        .busy(busy), .done(done), .result(result)
    );

    int errs = 0;
    int checks = 0;
    int cyc = 0;

    // converter model and link monitor state
    logic [11:0] next_word = '0;
    logic [11:0] word_q = '0;
    int r = 0, lo_run = 0, hi_run = 0, last_low = 0, last_gap = 0, last_rises = 0;
    logic p_cs = 1'b1, p_sclk = 1'b0;

    function automatic int exp_frame_len(input int h);
        return 32 * h;
    endfunction

    function automatic int exp_gap(input int g);
        return ((g < 1) ? 1 : g) + 1;
    endfunction

    // value the converter presents ahead of rising edge k
    function automatic logic bit_for(input logic [11:0] w, input int k);
        if (k >= 4 && k <= 15) return w[15 - k];
        return logic'($urandom() & 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (p_cs && !csn) begin
            last_gap = hi_run;
            hi_run = 0;
            lo_run = 0;
            r = 0;
            word_q = next_word;
            sdata = logic'($urandom() & 1);
        end
        if (!p_cs && csn) begin
            last_low = lo_run;
            last_rises = r;
        end
        if (!csn) lo_run++; else hi_run++;
        if (!csn && !p_sclk && sclk) r++;
        if (!csn && p_sclk && !sclk) sdata = bit_for(word_q, r + 1);
        p_cs = csn;
        p_sclk = sclk;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errs++;
            checks++;
            $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", cyc, 190000);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic wait_done();
        int n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R5 done seen", int'(done), 1);
    endtask

    task automatic one_frame(input logic [11:0] w, input logic pol, input int h, input int g);
        @(negedge clk);
        cpol = pol; half_div = DIV_W'(h); gap_min = GAP_W'(g); next_word = w;
        repeat (g + 4) @(negedge clk);
        chk(sclk == pol, "R3 idle level", int'(sclk), int'(pol));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(csn == 1'b0, "R2 select low after start", int'(csn), 0);
        chk(busy == 1'b1, "R6 busy in frame", int'(busy), 1);
        wait_done();
        chk(result == w, "R4 result word", int'(result), int'(w));
        chk(csn == 1'b1 && busy == 1'b0, "R6 busy drops with select", int'(busy), 0);
        @(negedge clk);
        chk(done == 1'b0, "R5 single pulse", int'(done), 0);
        chk(last_low == exp_frame_len(h), "R2 frame length", last_low, exp_frame_len(h));
        chk(last_rises == 16, "R3 rising edges", last_rises, 16);
        chk(result == w, "R5 result holds", int'(result), int'(w));
    endtask

    // second request raised in the done clock (at_done) or mid-frame
    task automatic chained(input logic [11:0] a, input logic [11:0] b, input int h,
                           input int g, input bit at_done);
        @(negedge clk);
        cpol = 1'b0; half_div = DIV_W'(h); gap_min = GAP_W'(g); next_word = a;
        repeat (g + 4) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!at_done) begin
            repeat (5 * h) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done();
        chk(result == a, "R4 first word", int'(result), int'(a));
        next_word = b;
        if (at_done) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (csn) @(negedge clk);
        @(negedge clk);
        chk(last_gap == exp_gap(g), "R7 held start gap", last_gap, exp_gap(g));
        wait_done();
        chk(result == b, "R7 held frame word", int'(result), int'(b));
        @(negedge clk);
    endtask

    task automatic reject(input int h);
        int lows = 0;
        @(negedge clk);
        half_div = DIV_W'(h); gap_min = '0;
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) begin
            if (!csn || busy) lows++;
            @(negedge clk);
        end
        chk(lows == 0, "R8 out-of-range divider refused", lows, 0);
        half_div = DIV_W'(MIN_H);
        repeat (3) @(negedge clk);
        chk(csn == 1'b1, "R8 dropped request not served later", int'(csn), 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(csn == 1'b1, "R1 select after reset", int'(csn), 1);
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done after reset", int'(busy), 0);
        chk(result == '0, "R1 result after reset", int'(result), 0);
        chk(sclk == cpol, "R1 idle level after reset", int'(sclk), int'(cpol));

        one_frame(12'h000, 1'b0, MIN_H, 0);
        one_frame(12'hFFF, 1'b1, MIN_H, 3);
        one_frame(12'hA5A, 1'b0, MIN_H + 7, 2);
        one_frame(12'hA5A, 1'b1, MIN_H + 7, 2);
        one_frame(12'h801, 1'b1, MIN_H + 1, 0);

        chained(12'h123, 12'hEDC, MIN_H, 6, 1'b1);
        chained(12'h3C3, 12'h001, MIN_H + 2, 0, 1'b0);
        chained(12'hFFE, 12'h7FF, MIN_H, 1, 1'b1);

        reject(MIN_H - 1);
        reject(MAX_H + 1);
        reject(0);

        for (int i = 0; i < 8; i++) begin
            one_frame(12'($urandom()), logic'($urandom() & 1),
                      MIN_H + int'($urandom() % 12), int'($urandom() % 10));
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule